// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software run clause-22 management transactions on a serial MDC/MDIO pair through a single 32-bit command/status word. The word carries the PHY address, the register address, a read or write request and the write data. Writing a word with a request bit set starts one serial frame on the pins. When the frame ends, the block sets a completion flag in the same word. For a read it also places the 16-bit value from the PHY in the upper half of the word.

The block has four parts. The command register decodes software writes and holds the pending command. A divider derives MDC from the system clock and runs only during a frame. A frame sequencer drives and samples the data line and controls the tristate enable. The sequencer's state machine has these states and transitions:
- ST_IDLE → ST_PREAMBLE when a start pulse arrives.
- ST_PREAMBLE → ST_HEADER after the last preamble bit.
- ST_HEADER → ST_TURN after the register-address LSB.
- ST_TURN → ST_DATA after the second turnaround bit.
- ST_DATA → ST_FINISH after the last data bit.
- ST_FINISH → ST_IDLE unconditionally, one cycle later. This is the cycle that raises completion.

The divider changes MDC only when its half-period counter wraps. Data changes on MDC falling edges, and the block samples read data on rising edges.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0, MDC is low and the data-line output enable is low.
- R2: The command word keeps the PHY address in bits 4:0 and the register address in bits 12:8. Bits 7:5 always read 0. The accepted command stays visible until completion, with its request bit (13 write, 14 read) still set.
- R3: Writing a word with bit 14 set starts a read, and writing a word with only bit 13 set starts a write. If both bits are set, the block runs a read.
- R4: Each frame is 32 ones, then 01, then the opcode (10 read, 01 write), then the 5-bit PHY address and the 5-bit register address. All fields are sent MSB first, and each frame bit lasts one MDC period.
- R5: On a write, the block drives 1 then 0 in the turnaround, followed by bits 31:16 of the command word, MSB first.
- R6: On a read, the output enable is low through the turnaround and the 16 data bits. The data line is sampled on each MDC rising edge, and the 16 samples appear in bits 31:16 at completion.
- R7: At completion, bit 15 is set and bits 14:13 clear. Writing a 1 to bit 15 clears the flag. Writing 0 to bit 15 leaves the flag unchanged.
- R8: While a command is pending, every register write is ignored: fields, flag and request bits stay as they are, and no further frame runs.
- R9: MDC idles low. Its high and low phases each last HALF_DIV clock cycles (default 40, which gives 2.5 MHz from 200 MHz). A transaction completes within 64·2·HALF_DIV + 4 cycles of the command write.
- R10: The driven data line changes only while MDC is low, never during an MDC high phase.
- R11: Accepting a new command clears a completion flag left set by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Write strobe for the command word |
| csr_wdata | input | 32 | Command word write value |
| csr_rdata | output | 32 | Command word read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A register write shows in the read-back word at the first falling clock edge after the write. The bench samples the read-back word there to check field layout, request bits, clearing of the flag and ignored writes. Frame bits are due at the MDC rising edges, so a PHY model records the line at each rise and drives read data after each fall. The completion flag is due about 64·2·HALF_DIV + 3 cycles after the write. The bench polls the flag once per cycle on the falling clock edge and checks that the latency falls inside a bounded window rather than at one fixed cycle. After completion, the bench waits several hundred cycles and confirms that MDC stays low and no extra frame bits appear.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int CSR_W    = 32;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PHY_LSB  = 0;
    localparam int REG_LSB  = 8;
    localparam int WR_BIT   = 13;
    localparam int RD_BIT   = 14;
    localparam int DONE_BIT = 15;
    localparam int DATA_LSB = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } mdio_state_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap    = run && (cnt == CNT_LAST);
    assign rise_ev = wrap && !mdc;
    assign fall_ev = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_cmd_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int TOTAL    = PRE_LEN + 32;
    localparam int BCNT_W   = $clog2(TOTAL + 1);
    localparam logic [BCNT_W-1:0] PRE_END  = BCNT_W'(PRE_LEN - 1);
    localparam logic [BCNT_W-1:0] HDR_END  = BCNT_W'(PRE_LEN + 13);
    localparam logic [BCNT_W-1:0] TURN_END = BCNT_W'(PRE_LEN + 15);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(TOTAL - 1);

    mdio_state_e       state, state_nx;
    logic [TOTAL-1:0]  shreg;
    logic [BCNT_W-1:0] bit_cnt;
    logic              is_rd;
    logic [DATA_W-1:0] rd_sh;
    logic [TOTAL-1:0]  frame_load;

    assign frame_load = {{PRE_LEN{1'b1}}, 2'b01,
                         (cmd.is_read ? 2'b10 : 2'b01),
                         cmd.phy, cmd.regad, 2'b10,
                         (cmd.is_read ? {DATA_W{1'b0}} : cmd.wdata)};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_ev && bit_cnt == PRE_END)  state_nx = ST_HEADER;
            ST_HEADER:   if (fall_ev && bit_cnt == HDR_END)  state_nx = ST_TURN;
            ST_TURN:     if (fall_ev && bit_cnt == TURN_END) state_nx = ST_DATA;
            ST_DATA:     if (fall_ev && bit_cnt == LAST_BIT) state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            is_rd   <= 1'b0;
            rd_sh   <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                shreg   <= frame_load;
                bit_cnt <= '0;
                is_rd   <= cmd.is_read;
            end else if (fall_ev) begin
                shreg   <= {shreg[TOTAL-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (rise_ev && state == ST_DATA && is_rd)
                rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_oe = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_PREAMBLE: begin run = 1'b1; mdio_oe = 1'b1; end
            ST_HEADER:   begin run = 1'b1; mdio_oe = 1'b1; end
            ST_TURN:     begin run = 1'b1; mdio_oe = !is_rd; end
            ST_DATA:     begin run = 1'b1; mdio_oe = !is_rd; end
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
        mdio_o   = mdio_oe & shreg[TOTAL-1];
        rd_value = rd_sh;
    end

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == ST_IDLE);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_value,
    output logic              start,
    output mdio_cmd_t         cmd,
    output logic [CSR_W-1:0]  rdata
);
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] data_q;
    logic              rd_pend, wr_pend, done_flg, start_q;
    logic              busy, req;

    assign busy = rd_pend | wr_pend;
    assign req  = wdata[RD_BIT] | wdata[WR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q    <= '0;
            reg_q    <= '0;
            data_q   <= '0;
            rd_pend  <= 1'b0;
            wr_pend  <= 1'b0;
            done_flg <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (done) begin
                done_flg <= 1'b1;
                rd_pend  <= 1'b0;
                wr_pend  <= 1'b0;
                if (rd_pend) data_q <= rd_value;
            end else if (wr_en && !busy) begin
                if (req) begin
                    phy_q    <= wdata[PHY_LSB +: ADDR_W];
                    reg_q    <= wdata[REG_LSB +: ADDR_W];
                    data_q   <= wdata[DATA_LSB +: DATA_W];
                    rd_pend  <= wdata[RD_BIT];
                    wr_pend  <= !wdata[RD_BIT];
                    done_flg <= 1'b0;
                    start_q  <= 1'b1;
                end else if (wdata[DONE_BIT]) begin
                    done_flg <= 1'b0;
                end
            end
        end
    end

    assign start       = start_q;
    assign cmd.is_read = rd_pend;
    assign cmd.phy     = phy_q;
    assign cmd.regad   = reg_q;
    assign cmd.wdata   = data_q;
    assign rdata       = {data_q, done_flg, rd_pend, wr_pend, reg_q, 3'b000, phy_q};

    // R3
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pend, wr_pend}));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(phy_q) && $stable(reg_q) && $stable(data_q) && !done_flg));

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flg) |-> $past(done));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 40,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start, run, rise_ev, fall_ev, done;
    logic [DATA_W-1:0] rd_value;
    mdio_cmd_t         cmd;

    mdio_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr),
        .wdata    (csr_wdata),
        .done     (done),
        .rd_value (rd_value),
        .start    (start),
        .cmd      (cmd),
        .rdata    (csr_rdata)
    );

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .mdio_i   (mdio_i),
        .run      (run),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_value (rd_value)
    );

    // R10
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drv = 1'b1;
    wire         mdio_bus = mdio_oe ? mdio_o : phy_drv;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mdio_cmd_ctrl u_mdio_cmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_bus)
    );

    // PHY model
    int          rc = 0;
    logic [63:0] cap = '0;
    logic [15:0] phy_rdval = '0;
    bit          phy_rd_mode = 1'b0;
    int          oe_viol = 0;
    int          hold_viol = 0;
    int          phase_bad = 0;
    realtime     t_rise = 0;

    always @(posedge mdc) begin
        if (rc < 64) cap[63 - rc] = mdio_bus;
        if (phy_rd_mode && rc >= 46 && mdio_oe) oe_viol++;
        rc++;
        t_rise = $realtime;
    end

    always @(negedge mdc) begin
        if ($realtime - t_rise != 200.0) phase_bad++;
        phy_drv = (rc >= 48 && rc < 64) ? phy_rdval[63 - rc] : 1'b1;
    end

    logic prev_mdc = 1'b0, prev_o = 1'b0;
    always @(negedge clk) begin
        if (mdc && prev_mdc && mdio_oe && mdio_o != prev_o) hold_viol++;
        prev_mdc = mdc;
        prev_o   = mdio_o;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(bit rd, bit wr, bit dn, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
        return {d, dn, rd, wr, ra, 3'b000, phy};
    endfunction

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
    endfunction

    task automatic csr_write(input logic [31:0] w);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = w;
        @(negedge clk);
        csr_wr = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic run_txn(input bit rd, input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, input bit mid_write);
        bit          eff_rd;
        int          n;
        logic [31:0] snap;
        logic [63:0] ef;
        eff_rd      = rd;
        phy_rdval   = 16'($urandom);
        phy_rd_mode = eff_rd;
        rc = 0; oe_viol = 0; hold_viol = 0; phase_bad = 0;
        csr_write(mk_cmd(rd, wr, 1'b0, phy, ra, d));
        // R2 R11 readback of pending command, flag cleared
        snap = mk_cmd(eff_rd, !eff_rd, 1'b0, phy, ra, d);
        check(csr_rdata == snap, "R2/R11 pending readback", 64'(csr_rdata), 64'(snap));
        n = 1;
        while (csr_rdata[15] == 1'b0 && n < 6000) begin
            if (mid_write && n == 1000) begin
                csr_write(mk_cmd(1'b0, 1'b1, 1'b1, 5'd7, 5'd9, 16'h1234));
                n += 2;
                // R8 write while busy ignored
                check(csr_rdata == snap, "R8 busy write ignored", 64'(csr_rdata), 64'(snap));
            end else begin
                @(negedge clk);
                n++;
            end
        end
        // R9 latency window
        check(n >= 5100 && n <= 5140, "R9 completion latency", 64'(n), 64'(5124));
        check(phase_bad == 0, "R9 MDC high phase", 64'(phase_bad), 64'(0));
        ef = exp_frame(eff_rd, phy, ra, eff_rd ? phy_rdval : d);
        // R4 frame header
        check(cap[63:18] == ef[63:18], "R4 frame header", cap, ef);
        check(hold_viol == 0, "R10 data stable while MDC high", 64'(hold_viol), 64'(0));
        if (eff_rd) begin
            check(oe_viol == 0, "R6 line released", 64'(oe_viol), 64'(0));
            check(csr_rdata[31:16] == phy_rdval, "R6 read value", 64'(csr_rdata[31:16]), 64'(phy_rdval));
        end else begin
            check(cap[17:0] == ef[17:0], "R5 turnaround and write data", 64'(cap[17:0]), 64'(ef[17:0]));
        end
        // R7 flag set, request bits cleared
        check(csr_rdata[15:13] == 3'b100, "R7 completion bits", 64'(csr_rdata[15:13]), 64'(3'b100));
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(csr_rdata == 32'h0, "R1 reset word", 64'(csr_rdata), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {62'h0, mdc, mdio_oe}, 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mdc == 1'b0, "R9 MDC idle low", 64'(mdc), 64'h0);

        // directed: write, extreme addresses
        run_txn(1'b0, 1'b1, 5'd31, 5'd31, 16'hA5C3, 1'b0);
        // R7 writing zero to flag keeps it
        csr_write(32'h0);
        check(csr_rdata[15] == 1'b1, "R7 zero write keeps flag", 64'(csr_rdata[15]), 64'h1);
        csr_write(32'h0000_8000);
        check(csr_rdata[15] == 1'b0, "R7 W1C clears flag", 64'(csr_rdata[15]), 64'h0);
        // R2 bits 7:5 read zero
        csr_write(32'h0000_00E0);
        check(csr_rdata[7:5] == 3'b000, "R2 reserved bits zero", 64'(csr_rdata[7:5]), 64'h0);

        // directed: read with busy write; flag left set from nothing
        run_txn(1'b1, 1'b0, 5'd5, 5'd3, 16'h0000, 1'b1);
        repeat (300) @(negedge clk);
        check(rc == 64 && mdc == 1'b0, "R8 no extra frame", 64'(rc), 64'(64));

        // R3 both request bits -> read; R11 flag still set from previous
        run_txn(1'b1, 1'b1, 5'd0, 5'd0, 16'hFFFF, 1'b0);
        run_txn(1'b0, 1'b1, 5'd0, 5'd0, 16'h0000, 1'b0);

        for (int i = 0; i < 8; i++) begin
            bit r;
            r = 1'($urandom);
            if (i % 2 == 0) csr_write(32'h0000_8000);
            run_txn(r, !r, 5'($urandom), 5'($urandom), 16'($urandom), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule